// File: doc/BRIEF.md
# GPIO Pin Interrupt Aggregator

This block turns a bank of general purpose input pins, grouped into ports, into one shared interrupt request. Each pin carries an enable bit and a two-bit trigger type that selects no trigger, a rising edge, a falling edge, or a difference from a reference value. That reference is taken from the pin each time software reads the pin's port. Rising and falling events set a sticky per-pin flag that software clears by writing a one. A change-mode pin stays active for as long as the live pin differs from its reference. A port read therefore clears it, as long as the pin stays where it is.

All per-pin outputs feed one OR. The request flip-flop is set only on the rising edge of that OR, and only while both the group mask and the global enable are set. An acknowledge pulse clears it. While any pin output stays high, further pin events cannot raise a new request. Software must clear every source before the next event can be seen. Pin inputs are asynchronous and pass through a two-flop synchronizer.

The register port is a plain single-cycle write with a combinational read of the addressed register. There is no stream data path, so no valid/ready handshake is used.

Top module: `gpio_irq_agg`

## Requirements
- R1: After reset, `irq_o` is 0 and every enable, trigger-type, pending and global control register reads as 0.
- R2: A pin whose enable bit is 0 never shows as pending and never contributes to the request, whatever its trigger type and pin activity.
- R3: A pin with trigger type 00 (both type bits 0) never shows as pending, even when enabled.
- R4: With type 01 (rising) and enabled, a 0-to-1 pin transition sets the pin's pending bit. The bit survives port reads and clears when a 1 is written to that bit position of the pending register. A 1-to-0 transition does not set it.
- R5: With type 10 (falling) and enabled, a 1-to-0 transition sets the pending bit, with the same sticky, write-one-to-clear behaviour. A 0-to-1 transition does not set it.
- R6: With type 11 (change) and enabled, the pending bit is 1 exactly while the synchronized pin differs from the value captured at the most recent read of that port. A port read recaptures the value, so a stable pin then shows 0.
- R7: `irq_o` is set one cycle after the OR of all pending outputs rises. While any output stays high, new pin events raise no new request.
- R8: The request is set only when the group mask (global register bit 0) and the global enable (bit 1) are both 1. A rise of the OR while either is 0 is dropped and is not raised later.
- R9: A cycle with `irq_ack` high clears `irq_o`. If a set and an acknowledge fall in the same cycle, the set wins.
- R10: A pin change reaches the pending register three clock edges after it is applied: two synchronizer edges and one flag edge. The request follows one edge after that.
- R11: Register map: port p uses address p*4+r, with r=0 enable, r=1 type low bit, r=2 type high bit, r=3 pending (read) / clear (write). Bit i of each register belongs to pin i of the port. The global register sits at address NUM_PORTS*4. `port_rd_data` returns the synchronized pins of the port chosen by `port_rd_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pins_i | input | NUM_PORTS*PINS_PER_PORT | Asynchronous pin inputs, port p in bits p*PINS_PER_PORT upward |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | PW+2 | Register address |
| reg_wdata | input | PINS_PER_PORT | Register write data |
| reg_rdata | output | PINS_PER_PORT | Contents of the addressed register |
| port_rd_en | input | 1 | Port read strobe; captures change-mode references |
| port_rd_sel | input | PW | Port selected for the read |
| port_rd_data | output | PINS_PER_PORT | Synchronized pin values of the selected port |
| irq_ack | input | 1 | Acknowledge, clears the request |
| irq_o | output | 1 | Shared interrupt request |

## Verification
The bench builds the block with two ports of two pins, so four pins cover both the port decode and the bit position inside a port. At that size every pin can be swept through all four trigger types, both enable values and both transition directions. Each case also checks how it responds to a port read and to a write-one clear. Timed sequences on the same configuration check the three-edge latency, the case where a held source blocks later events, and same-cycle set and acknowledge. They also check that a rise seen while masked is lost, and that change-mode pins in the second port reach the shared request.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  typedef enum logic [1:0] {
    TRIG_OFF    = 2'b00,
    TRIG_RISE   = 2'b01,
    TRIG_FALL   = 2'b10,
    TRIG_CHANGE = 2'b11
  } trig_e;

  localparam logic [1:0] REG_ENABLE = 2'd0;
  localparam logic [1:0] REG_TYPE_LO = 2'd1;
  localparam logic [1:0] REG_TYPE_HI = 2'd2;
  localparam logic [1:0] REG_PENDING = 2'd3;
endpackage

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
  import gpio_irq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  pin_i,
  input  logic  en_i,
  input  trig_e trig_i,
  input  logic  clr_i,
  input  logic  snap_i,
  output logic  sync_o,
  output logic  out_o
);
  logic stage_a, stage_b, prev_q, flag_q, ref_q;
  logic edge_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_a <= 1'b0;
      stage_b <= 1'b0;
      prev_q  <= 1'b0;
    end else begin
      stage_a <= pin_i;
      stage_b <= stage_a;
      prev_q  <= stage_b;
    end
  end

  always_comb begin
    edge_hit = en_i && (((trig_i == TRIG_RISE) && stage_b && !prev_q) ||
                        ((trig_i == TRIG_FALL) && !stage_b && prev_q));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= 1'b0;
    else if (edge_hit) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ref_q <= 1'b0;
    else if (snap_i) ref_q <= stage_b;
  end

  assign sync_o = stage_b;
  assign out_o  = en_i && ((trig_i == TRIG_CHANGE) ? (stage_b ^ ref_q)
                                                    : ((trig_i != TRIG_OFF) && flag_q));

  AST_FLAG_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(en_i && ((trig_i == TRIG_RISE) || (trig_i == TRIG_FALL)))) // R4
    else $error("flag set without an enabled edge trigger");
  AST_CLEAR_DROPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !edge_hit) |=> !flag_q) // R4
    else $error("clear did not drop flag");
  AST_SNAP_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_i && $stable(stage_b)) |=> !(stage_b ^ ref_q) || !$stable(stage_b)) // R6
    else $error("reference not captured on port read");
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PORTS     = 6,
  parameter int PINS_PER_PORT = 8,
  parameter int PW            = $clog2(NUM_PORTS + 1),
  localparam int NPINS        = NUM_PORTS * PINS_PER_PORT,
  localparam int AW           = PW + 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [AW-1:0]            addr,
  input  logic [PINS_PER_PORT-1:0] wdata,
  input  logic [NPINS-1:0]         pend_i,
  output logic [PINS_PER_PORT-1:0] rdata,
  output logic [NPINS-1:0]         en_o,
  output logic [NPINS-1:0]         tlo_o,
  output logic [NPINS-1:0]         thi_o,
  output logic [NPINS-1:0]         clr_o,
  output logic                     grp_mask_o,
  output logic                     glb_en_o
);
  logic [PW-1:0] port_f;
  logic [1:0]    sel_f;
  assign port_f = addr[AW-1:2];
  assign sel_f  = addr[1:0];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    localparam logic [PW-1:0] PIDX = PW'(p);
    logic hit;
    assign hit = wr_en && (port_f == PIDX);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        en_o [p*PINS_PER_PORT +: PINS_PER_PORT] <= '0;
        tlo_o[p*PINS_PER_PORT +: PINS_PER_PORT] <= '0;
        thi_o[p*PINS_PER_PORT +: PINS_PER_PORT] <= '0;
      end else if (hit) begin
        if (sel_f == REG_ENABLE)  en_o [p*PINS_PER_PORT +: PINS_PER_PORT] <= wdata;
        if (sel_f == REG_TYPE_LO) tlo_o[p*PINS_PER_PORT +: PINS_PER_PORT] <= wdata;
        if (sel_f == REG_TYPE_HI) thi_o[p*PINS_PER_PORT +: PINS_PER_PORT] <= wdata;
      end
    end
    assign clr_o[p*PINS_PER_PORT +: PINS_PER_PORT] =
      (hit && sel_f == REG_PENDING) ? wdata : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grp_mask_o <= 1'b0;
      glb_en_o   <= 1'b0;
    end else if (wr_en && port_f == PW'(NUM_PORTS) && sel_f == REG_ENABLE) begin
      grp_mask_o <= wdata[0];
      glb_en_o   <= wdata[1];
    end
  end

  always_comb begin
    rdata = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (port_f == PW'(p)) begin
        case (sel_f)
          REG_ENABLE:  rdata = en_o  [p*PINS_PER_PORT +: PINS_PER_PORT];
          REG_TYPE_LO: rdata = tlo_o [p*PINS_PER_PORT +: PINS_PER_PORT];
          REG_TYPE_HI: rdata = thi_o [p*PINS_PER_PORT +: PINS_PER_PORT];
          default:     rdata = pend_i[p*PINS_PER_PORT +: PINS_PER_PORT];
        endcase
      end
    end
    if (port_f == PW'(NUM_PORTS) && sel_f == REG_ENABLE) begin
      rdata[0] = grp_mask_o;
      rdata[1] = glb_en_o;
    end
  end
endmodule

// File: rtl/gpio_irq_gate.sv
module gpio_irq_gate #(
  parameter int NSRC = 48
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic            grp_mask_i,
  input  logic            glb_en_i,
  input  logic            ack_i,
  output logic            irq_o
);
  logic any_src, any_q, set_req;

  assign any_src = |src_i;
  assign set_req = any_src && !any_q && grp_mask_i && glb_en_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      any_q <= 1'b0;
      irq_o <= 1'b0;
    end else begin
      any_q <= any_src;
      if (set_req) irq_o <= 1'b1;
      else if (ack_i) irq_o <= 1'b0;
    end
  end

  AST_RISE_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(src_i != '0)) // R7
    else $error("request without a source");
  AST_RISE_NEEDS_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(grp_mask_i && glb_en_i)) // R8
    else $error("request while masked");
  AST_FALL_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_o) |-> $past(ack_i)) // R9
    else $error("request dropped without acknowledge");
endmodule

// File: rtl/gpio_irq_agg.sv
module gpio_irq_agg
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PORTS     = 6,
  parameter int PINS_PER_PORT = 8,
  localparam int PW           = $clog2(NUM_PORTS + 1),
  localparam int AW           = PW + 2,
  localparam int NPINS        = NUM_PORTS * PINS_PER_PORT
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NPINS-1:0]         pins_i,
  input  logic                     reg_wr_en,
  input  logic [AW-1:0]            reg_addr,
  input  logic [PINS_PER_PORT-1:0] reg_wdata,
  output logic [PINS_PER_PORT-1:0] reg_rdata,
  input  logic                     port_rd_en,
  input  logic [PW-1:0]            port_rd_sel,
  output logic [PINS_PER_PORT-1:0] port_rd_data,
  input  logic                     irq_ack,
  output logic                     irq_o
);
  logic [NPINS-1:0] en_v, tlo_v, thi_v, clr_v, pend_v, sync_v, snap_v;
  logic grp_mask, glb_en;

  gpio_irq_regs #(.NUM_PORTS(NUM_PORTS), .PINS_PER_PORT(PINS_PER_PORT), .PW(PW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr), .wdata(reg_wdata),
    .pend_i(pend_v), .rdata(reg_rdata), .en_o(en_v), .tlo_o(tlo_v), .thi_o(thi_v),
    .clr_o(clr_v), .grp_mask_o(grp_mask), .glb_en_o(glb_en)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    localparam logic [PW-1:0] OWNER = PW'(i / PINS_PER_PORT);
    assign snap_v[i] = port_rd_en && (port_rd_sel == OWNER);
    gpio_pin_cell u_cell (
      .clk(clk), .rst_n(rst_n), .pin_i(pins_i[i]), .en_i(en_v[i]),
      .trig_i(trig_e'({thi_v[i], tlo_v[i]})), .clr_i(clr_v[i]), .snap_i(snap_v[i]),
      .sync_o(sync_v[i]), .out_o(pend_v[i])
    );
  end

  always_comb begin
    port_rd_data = '0;
    for (int p = 0; p < NUM_PORTS; p++)
      if (port_rd_sel == PW'(p)) port_rd_data = sync_v[p*PINS_PER_PORT +: PINS_PER_PORT];
  end

  gpio_irq_gate #(.NSRC(NPINS)) u_gate (
    .clk(clk), .rst_n(rst_n), .src_i(pend_v), .grp_mask_i(grp_mask),
    .glb_en_i(glb_en), .ack_i(irq_ack), .irq_o(irq_o)
  );

  AST_DISABLED_PIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (en_v == '0) |-> (pend_v == '0)) // R2
    else $error("pending output from disabled pins");
endmodule

// File: tb/gpio_irq_agg_bench.sv
module gpio_irq_agg_bench;
  localparam int NP = 2;
  localparam int PP = 2;
  localparam int PW = $clog2(NP + 1);
  localparam int AW = PW + 2;
  localparam int N  = NP * PP;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] pins = '0;
  logic wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [PP-1:0] wdata = '0;
  logic [PP-1:0] rdata;
  logic prd_en = 1'b0;
  logic [PW-1:0] prd_sel = '0;
  logic [PP-1:0] prd_data;
  logic ack = 1'b0;
  logic irq;
  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  gpio_irq_agg #(.NUM_PORTS(NP), .PINS_PER_PORT(PP)) u_gpio_irq_agg (
    .clk(clk), .rst_n(rst_n), .pins_i(pins), .reg_wr_en(wr_en), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .port_rd_en(prd_en), .port_rd_sel(prd_sel),
    .port_rd_data(prd_data), .irq_ack(ack), .irq_o(irq)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1'b1; addr = AW'(a); wdata = PP'(d);
    tick();
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    addr = AW'(a); #1; d = int'(rdata);
  endtask

  task automatic port_read(input int p);
    prd_en = 1'b1; prd_sel = PW'(p);
    tick();
    prd_en = 1'b0;
  endtask

  task automatic wait_n(input int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  task automatic clear_cfg();
    for (int p = 0; p < NP; p++) begin
      wr(p*4+0, 0); wr(p*4+1, 0); wr(p*4+2, 0); wr(p*4+3, 3);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    int v;
    int ok;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    check(int'(irq), 0, "R1 irq after reset");
    for (int a = 0; a <= NP*4; a++) begin
      rd(a, v);
      check(v, 0, "R1 register after reset");
    end

    // Sweep: every pin, type, enable and direction
    for (int pin = 0; pin < N; pin++)
      for (int t = 0; t < 4; t++)
        for (int en = 0; en < 2; en++)
          for (int v0 = 0; v0 < 2; v0++) begin
            int port, bit_i, exp1, exp2;
            string tag;
            port = pin / PP; bit_i = pin % PP;
            clear_cfg();
            pins = '0; pins[pin] = v0[0];
            wait_n(4);
            port_read(0); port_read(1);
            wr(port*4+3, 3);
            wr(port*4+0, en << bit_i);
            wr(port*4+1, t[0] << bit_i);
            wr(port*4+2, t[1] << bit_i);
            pins[pin] = ~v0[0];
            wait_n(4);
            ok = (en == 1) && ((t == 1 && v0 == 0) || (t == 2 && v0 == 1) || t == 3);
            exp1 = ok << bit_i;
            tag = (en == 0) ? "R2" : (t == 0) ? "R3" : (t == 1) ? "R4" : (t == 2) ? "R5" : "R6";
            rd(port*4+3, v);
            check(v, exp1, {tag, " pending after transition"});
            prd_sel = PW'(port); #1;
            check(int'(prd_data), int'(pins[port*PP +: PP]), "R11 port read data");
            port_read(port);
            exp2 = (t == 3) ? 0 : exp1;
            rd(port*4+3, v);
            check(v, exp2, {tag, " pending after port read"});
            wr(port*4+3, 1 << bit_i);
            rd(port*4+3, v);
            check(v, 0, {tag, " pending after write-one clear"});
          end

    clear_cfg();
    pins = '0;
    wait_n(4);
    port_read(0); port_read(1);

    // R8: masked rise is dropped and never raised later
    wr(0, 1); wr(1, 1);
    pins[0] = 1'b1; wait_n(6);
    check(int'(irq), 0, "R8 masked rise");
    wr(NP*4, 1); wait_n(4);
    check(int'(irq), 0, "R8 mask only, no global enable");
    wr(NP*4, 3); wait_n(4);
    check(int'(irq), 0, "R8 rise while masked not remembered");
    wr(3, 3); pins = '0; wait_n(4);

    // R10 latency, R7 set, R9 set beats ack
    pins[0] = 1'b1; ack = 1'b1;
    tick(); rd(3, v); check(v, 0, "R10 edge 1");
    tick(); rd(3, v); check(v, 0, "R10 edge 2");
    tick(); rd(3, v); check(v, 1, "R10 edge 3");
    check(int'(irq), 0, "R10 irq not yet");
    tick(); check(int'(irq), 1, "R9 set wins over ack");
    tick(); check(int'(irq), 0, "R9 ack clears");
    ack = 1'b0;

    // R7 blocking while a source is held
    wr(0, 3); wr(1, 3);
    pins[1] = 1'b1; wait_n(6);
    check(int'(irq), 0, "R7 blocked by held source");
    wr(3, 1); wait_n(3);
    check(int'(irq), 0, "R7 still blocked by pin 1");
    rd(3, v); check(v, 2, "R4 selective clear");
    wr(3, 3); pins = '0; wait_n(4);
    pins[1] = 1'b1; wait_n(6);
    check(int'(irq), 1, "R7 new rise after all cleared");
    ack = 1'b1; tick(); ack = 1'b0;
    check(int'(irq), 0, "R9 ack pulse");
    wr(3, 3); clear_cfg(); pins = '0; wait_n(4);

    // R6 change mode on second port reaches the shared request
    port_read(1);
    wr(4, 1); wr(5, 1); wr(6, 1);
    pins[2] = 1'b1; wait_n(5);
    check(int'(irq), 1, "R6 change on port 1 raises request");
    ack = 1'b1; tick(); ack = 1'b0;
    port_read(1);
    rd(7, v); check(v, 0, "R6 read recaptures reference");
    check(int'(irq), 0, "R6 request acknowledged");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule